// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block is the master side of a three-wire serial EEPROM link. The link has an active-high select, a serial clock, a data line to the memory and a data line from it. A client presents one command per handshake on a valid/ready request port. The command carries a two-bit opcode, a two-bit subcommand, an address, a 16-bit data word and a length field. The block builds the serial command frame and clocks it out most significant bit first. For a read it gathers the returned bits. For an operation that changes the array it waits until the memory reports that it has finished. One response pulse closes every command. That response carries the read word and an error flag.

All serial timing comes from a free-running tick with a period of one microsecond. The tick is divided down from the system clock. Every phase boundary on the serial pins falls on a tick. The client therefore only needs to set the clock ratio.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: A frame starts with a 1. Next come the opcode bits and then the ADDR_W address bits, all shifted out most significant first. The opcodes are 01 write, 10 read, 11 erase and 00 special.
- R2: For opcode 00, the subcommand fills the two highest address positions and every lower address bit is sent as 0. The subcommand codes are 11 program-enable, 00 program-disable, 01 fill-all and 10 wipe-all.
- R3: Write and fill-all append the low L bits of the data word, most significant first. L is the length field, except that 0 or any value above 16 gives L = 16. The other commands send no data bits.
- R4: The data line to the memory changes only while the serial clock is low. The clock stays high for at least one tick period and stays low for at least one tick period before each rising edge.
- R5: Select rises at least one tick period before the first clock edge. The clock is never high while select is low. Commands that need no busy wait raise select once.
- R6: A read issues one extra clock pulse after the frame and discards the bit returned on it. It then captures L bits, most significant first, at the end of each clock-high phase. These bits appear right-aligned on the response data. Every other command returns zero data.
- R7: Write, erase, fill-all and wipe-all end with a busy wait. Select drops for one tick period and rises again. The return line is then sampled once per tick. The first high sample ends the command with the error flag clear.
- R8: If ten samples in a row are low, the command ends with the error flag set.
- R9: Program-enable and program-disable skip the busy wait and report no error.
- R10: After reset, and after every command, select stays low for at least one tick period before the next request is accepted. While a command runs, req_ready stays low.
- R11: The response is a one-cycle pulse. It falls in the same cycle in which select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Opcode |
| req_sub | input | 2 | Subcommand, used when the opcode is 00 |
| req_addr | input | ADDR_W | Memory address |
| req_wdata | input | 16 | Data word for write or fill-all |
| req_len | input | 5 | Data length in bits (0 or above 16 means 16) |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Captured read bits, right-aligned |
| resp_err | output | 1 | Busy wait ran out of samples |
| ee_cs | output | 1 | Select to the memory, active high |
| ee_sck | output | 1 | Serial clock |
| ee_do | output | 1 | Serial data to the memory |
| ee_di | input | 1 | Serial data from the memory |

## Verification
The hardest case to reach from the ports is the edge of the busy-wait budget. The memory must stay busy for exactly nine samples and then show ready in time for the tenth. In the other case it stays busy for all ten, so the command ends as a timeout. The bench memory model counts ticks from the second rise of select in a command. It raises the return line only after a chosen number of low samples. Directed commands use nine and ten low samples, and random commands draw the count from 0 to 11. A second hard case is the read path, where the bit on the dummy pulse must be dropped. The model drives that bit as 0 and drives the data bits on the pulses after it, so any off-by-one in the capture changes the returned word.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned LEN_W  = 5;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } uw_op_e;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_WIPE   = 2'b10,
        SUB_UNLOCK = 2'b11
    } uw_sub_e;

    typedef enum logic [2:0] {
        S_GAP,
        S_IDLE,
        S_ARM,
        S_LO,
        S_HI,
        S_BLINK,
        S_POLL
    } uw_state_e;

    typedef struct packed {
        logic carries_data;
        logic is_read;
        logic needs_poll;
    } uw_kind_t;

    function automatic uw_kind_t classify(uw_op_e op, uw_sub_e sub);
        uw_kind_t k;
        k.is_read      = (op == OP_READ);
        k.carries_data = (op == OP_WRITE) || (op == OP_SPECIAL && sub == SUB_FILL);
        k.needs_poll   = (op == OP_WRITE) || (op == OP_ERASE) ||
                         (op == OP_SPECIAL && (sub == SUB_FILL || sub == SUB_WIPE));
        return k;
    endfunction

    // Zero or anything wider than a word means a full word.
    function automatic logic [LEN_W-1:0] clamp_len(logic [LEN_W-1:0] raw);
        return (raw == '0 || raw > LEN_W'(WORD_W)) ? LEN_W'(WORD_W) : raw;
    endfunction

endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uwire_frame.sv
module uwire_frame
    import uwire_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  uw_op_e                                       op,
    input  uw_sub_e                                      sub,
    input  logic [ADDR_W-1:0]                            addr,
    input  logic [WORD_W-1:0]                            wdata,
    input  logic [LEN_W-1:0]                             len,
    output logic [3+ADDR_W+WORD_W-1:0]                   frame,
    output logic [$clog2(3+ADDR_W+WORD_W+1)-1:0]         nsend,
    output logic [$clog2(3+ADDR_W+WORD_W+1)-1:0]         nread,
    output uw_kind_t                                     kind
);
    localparam int unsigned HDR_W   = 3 + ADDR_W;
    localparam int unsigned FRAME_W = HDR_W + WORD_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

    logic [LEN_W-1:0]  n_bits;
    logic [ADDR_W-1:0] afield;
    logic [WORD_W-1:0] dfield;

    always_comb begin
        kind   = classify(op, sub);
        n_bits = clamp_len(len);
        // Special commands carry their subcode in the top address bits.
        afield = (op == OP_SPECIAL) ? (ADDR_W'(sub) << (ADDR_W - 2)) : addr;
        // Left-align the low n_bits of the data word.
        dfield = kind.carries_data ? (wdata << (WORD_W - n_bits)) : '0;
        frame  = {1'b1, op, afield, dfield};
        nsend  = CNT_W'(HDR_W) + (kind.carries_data ? CNT_W'(n_bits) : '0);
        nread  = kind.is_read ? CNT_W'(n_bits) : '0;
    end
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
    import uwire_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned CLK_PER_US = 4,
    parameter int unsigned POLL_MAX   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_sub,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [4:0]        req_len,
    output logic              resp_valid,
    output logic [15:0]       resp_rdata,
    output logic              resp_err,
    output logic              ee_cs,
    output logic              ee_sck,
    output logic              ee_do,
    input  logic              ee_di
);
    localparam int unsigned FRAME_W = 3 + ADDR_W + WORD_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam int unsigned POLL_W  = $clog2(POLL_MAX + 1);

    logic tick;

    uwire_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    logic [FRAME_W-1:0] f_frame;
    logic [CNT_W-1:0]   f_nsend, f_nread;
    uw_kind_t           f_kind;

    uwire_frame #(.ADDR_W(ADDR_W)) u_frame (
        .op    (uw_op_e'(req_op)),
        .sub   (uw_sub_e'(req_sub)),
        .addr  (req_addr),
        .wdata (req_wdata),
        .len   (req_len),
        .frame (f_frame),
        .nsend (f_nsend),
        .nread (f_nread),
        .kind  (f_kind)
    );

    uw_state_e          state_q;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   send_q, rdl_q;
    logic               dummy_q;
    uw_kind_t           kind_q;
    logic [WORD_W-1:0]  rdata_q;
    logic [POLL_W-1:0]  poll_q;
    logic               cs_q, sck_q, resp_q, err_q;

    // Bookkeeping for the clock pulse that ends in this HI phase.
    logic             bit_cmd, capture, last_pulse, dummy_n;
    logic [CNT_W-1:0] send_n, rdl_n;

    always_comb begin
        bit_cmd    = (send_q != '0);
        send_n     = bit_cmd ? send_q - 1'b1 : send_q;
        dummy_n    = bit_cmd ? dummy_q : 1'b0;
        capture    = !bit_cmd && !dummy_q && (rdl_q != '0);
        rdl_n      = capture ? rdl_q - 1'b1 : rdl_q;
        last_pulse = (send_n == '0) && !dummy_n && (rdl_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_GAP;
            sh_q    <= '0;
            send_q  <= '0;
            rdl_q   <= '0;
            dummy_q <= 1'b0;
            kind_q  <= '0;
            rdata_q <= '0;
            poll_q  <= '0;
            cs_q    <= 1'b0;
            sck_q   <= 1'b0;
            resp_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            resp_q <= 1'b0;
            unique case (state_q)
                S_GAP: if (tick) state_q <= S_IDLE;
                S_IDLE: if (req_valid) begin
                    sh_q    <= f_frame;
                    send_q  <= f_nsend;
                    rdl_q   <= f_nread;
                    dummy_q <= f_kind.is_read;
                    kind_q  <= f_kind;
                    rdata_q <= '0;
                    state_q <= S_ARM;
                end
                S_ARM: if (tick) begin
                    cs_q    <= 1'b1;
                    state_q <= S_LO;
                end
                S_LO: if (tick) begin
                    sck_q   <= 1'b1;
                    state_q <= S_HI;
                end
                S_HI: if (tick) begin
                    sck_q   <= 1'b0;
                    send_q  <= send_n;
                    dummy_q <= dummy_n;
                    rdl_q   <= rdl_n;
                    if (bit_cmd) sh_q <= sh_q << 1;
                    if (capture) rdata_q <= {rdata_q[WORD_W-2:0], ee_di};
                    if (!last_pulse) begin
                        state_q <= S_LO;
                    end else if (kind_q.needs_poll) begin
                        cs_q    <= 1'b0;
                        state_q <= S_BLINK;
                    end else begin
                        cs_q    <= 1'b0;
                        resp_q  <= 1'b1;
                        err_q   <= 1'b0;
                        state_q <= S_GAP;
                    end
                end
                S_BLINK: if (tick) begin
                    cs_q    <= 1'b1;
                    poll_q  <= '0;
                    state_q <= S_POLL;
                end
                S_POLL: if (tick) begin
                    if (ee_di || poll_q == POLL_W'(POLL_MAX - 1)) begin
                        cs_q    <= 1'b0;
                        resp_q  <= 1'b1;
                        err_q   <= !ee_di;
                        state_q <= S_GAP;
                    end else begin
                        poll_q <= poll_q + 1'b1;
                    end
                end
                default: state_q <= S_GAP;
            endcase
        end
    end

    assign req_ready  = (state_q == S_IDLE);
    assign resp_valid = resp_q;
    assign resp_rdata = rdata_q;
    assign resp_err   = err_q;
    assign ee_cs      = cs_q;
    assign ee_sck     = sck_q;
    assign ee_do      = cs_q && bit_cmd && sh_q[FRAME_W-1];
endmodule

// File: rtl/uwire_ctrl_chk.sv
module uwire_ctrl_chk #(
    parameter int unsigned DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic sck,
    input logic dout,
    input logic req_ready,
    input logic resp_valid
);
    logic [31:0] hi_len, lo_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            hi_len <= sck ? hi_len + 1 : '0;
            lo_len <= (cs && !sck) ? lo_len + 1 : '0;
        end
    end

    p_high_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sck) |-> hi_len >= DIV);
    p_low_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> lo_len >= DIV);
    p_do_setup_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $stable(dout));
    p_do_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(dout));
    p_sck_in_cs_r5: assert property (@(posedge clk) disable iff (rst)
        sck |-> cs);
    p_cs_lead_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $past(cs));
    p_idle_desel_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!cs && !sck));
    p_resp_edge_r11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $fell(cs));
    p_resp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
endmodule

bind uwire_eeprom_ctrl uwire_ctrl_chk #(.DIV(CLK_PER_US)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs         (ee_cs),
    .sck        (ee_sck),
    .dout       (ee_do),
    .req_ready  (req_ready),
    .resp_valid (resp_valid)
);

// File: tb/uwire_eeprom_ctrl_bench.sv
module uwire_eeprom_ctrl_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 7;
    localparam int unsigned DIV        = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = '0, req_sub = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [4:0] req_len = '0;
    logic resp_valid, resp_err;
    logic [15:0] resp_rdata;
    logic ee_cs, ee_sck, ee_do, ee_di;

    always #(CLK_PERIOD/2) clk = ~clk;

    uwire_eeprom_ctrl #(.ADDR_W(ADDR_W), .CLK_PER_US(DIV), .POLL_MAX(10)) u_uwire_eeprom_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_sub(req_sub), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_len(req_len), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .resp_err(resp_err), .ee_cs(ee_cs),
        .ee_sck(ee_sck), .ee_do(ee_do), .ee_di(ee_di)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-command memory model configuration (written by the driver only).
    int          cfg_c = 0, cfg_len = 16, cfg_lows = 0;
    bit          cfg_rd = 0;
    logic [15:0] cfg_pat = '0;

    // Monitor state (written by the monitor only).
    logic        rd_din = 1'b0, poll_din = 1'b0;
    logic        p_cs = 1'b0, p_sck = 1'b0;
    int          rises = 0, mon_n = 0, pc = 0;
    bit          polling = 0;
    logic [63:0] mon_bits = '0;
    int          hi_run = 0, lo_run = 0, min_hi = 1000, min_lo = 1000;

    assign ee_di = rd_din | poll_din;

    always @(negedge clk) begin
        if (req_ready) begin
            rises = 0; mon_n = 0; mon_bits = '0; polling = 0; pc = 0;
            rd_din = 1'b0; poll_din = 1'b0;
        end else if (!rst) begin
            if (ee_cs && !p_cs) begin
                rises++;
                if (rises == 2) begin
                    polling = 1; pc = 0;
                    if (cfg_lows == 0) poll_din = 1'b1;
                end
            end else if (polling && ee_cs) begin
                pc++;
                if (pc == cfg_lows * DIV) poll_din = 1'b1;
            end
            if (!ee_cs && p_cs) polling = 0;
            if (ee_sck && !p_sck && ee_cs) begin
                if (cfg_rd && mon_n >= cfg_c + 1)
                    rd_din = cfg_pat[cfg_len - 1 - (mon_n - cfg_c - 1)];
                else
                    rd_din = 1'b0;
                mon_bits = {mon_bits[62:0], ee_do};
                mon_n++;
            end
        end
        if (ee_sck && !p_sck && lo_run < min_lo) min_lo = lo_run;
        if (!ee_sck && p_sck && hi_run < min_hi) min_hi = hi_run;
        hi_run = ee_sck ? hi_run + 1 : 0;
        lo_run = (ee_cs && !ee_sck) ? lo_run + 1 : 0;
        p_cs = ee_cs;
        p_sck = ee_sck;
    end

    function automatic int blen(input logic [4:0] l);
        return (l == 0 || l > 16) ? 16 : int'(l);
    endfunction

    function automatic logic [63:0] cmd_bits(input logic [1:0] op, input logic [1:0] sub,
                                             input logic [ADDR_W-1:0] addr, input logic [15:0] wd,
                                             input int L, output int n);
        logic [63:0] v;
        logic [ADDR_W-1:0] af;
        v = 64'd1;
        v = (v << 2) | 64'(op);
        af = (op == 2'b00) ? (ADDR_W'(sub) << (ADDR_W - 2)) : addr;
        v = (v << ADDR_W) | 64'(af);
        n = 3 + ADDR_W;
        if (op == 2'b01 || (op == 2'b00 && sub == 2'b01)) begin
            for (int i = L - 1; i >= 0; i--) v = (v << 1) | 64'(wd[i]);
            n += L;
        end
        return v;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [1:0] sub, input logic [ADDR_W-1:0] addr,
                          input logic [15:0] wd, input logic [4:0] len, input logic [15:0] pat,
                          input int lows);
        int L, c, guard, expn, gap;
        logic [63:0] cmd, expbits;
        logic [15:0] expd;
        bit rd, prog, data, prev_cs;
        string ftag;
        L = blen(len);
        cmd = cmd_bits(op, sub, addr, wd, L, c);
        rd = (op == 2'b10);
        data = (op == 2'b01) || (op == 2'b00 && sub == 2'b01);
        prog = (op == 2'b01) || (op == 2'b11) || (op == 2'b00 && (sub == 2'b01 || sub == 2'b10));
        ftag = (op == 2'b00) ? "R2 frame" : (data ? "R3 frame" : "R1 frame");
        expbits = rd ? (cmd << (1 + L)) : cmd;
        expn = rd ? c + 1 + L : c;
        expd = rd ? (pat & ((L == 16) ? 16'hFFFF : 16'((1 << L) - 1))) : 16'h0;

        @(negedge clk);
        guard = 0;
        while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
        cfg_c = c; cfg_rd = rd; cfg_len = L; cfg_pat = pat; cfg_lows = lows;
        req_op = op; req_sub = sub; req_addr = addr; req_wdata = wd; req_len = len;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 busy during command", 64'(req_ready), 64'd0);
        guard = 0; prev_cs = ee_cs;
        while (!resp_valid && guard < 5000) begin
            prev_cs = ee_cs; @(negedge clk); guard++;
        end
        if (!resp_valid) begin
            chk(1'b0, "R7 no response", 64'd0, 64'd1);
            return;
        end
        chk(mon_bits == expbits, ftag, mon_bits, expbits);
        chk(mon_n == expn, {ftag, " pulse count"}, 64'(mon_n), 64'(expn));
        chk(resp_rdata == expd, "R6 read data", 64'(resp_rdata), 64'(expd));
        if (prog) begin
            chk(rises == 2, "R7 select reraised for busy wait", 64'(rises), 64'd2);
            chk(resp_err == (lows >= 10), (lows >= 10) ? "R8 timeout flag" : "R7 ready flag",
                64'(resp_err), 64'(lows >= 10));
        end else begin
            chk(rises == 1, (op == 2'b00) ? "R9 no busy wait" : "R5 single select",
                64'(rises), 64'd1);
            chk(resp_err == 1'b0, "R9 no error", 64'(resp_err), 64'd0);
        end
        chk(!ee_cs && prev_cs, "R11 response at select fall", 64'({prev_cs, ee_cs}), 64'b10);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R11 single-cycle response", 64'(resp_valid), 64'd0);
        gap = 1;
        while (!req_ready && gap < 5000) begin @(negedge clk); gap++; end
        chk(gap >= DIV, "R10 deselect gap", 64'(gap), 64'(DIV));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk({ee_cs, ee_sck, ee_do, resp_valid, req_ready} == 5'b0, "R10 reset state",
            64'({ee_cs, ee_sck, ee_do, resp_valid, req_ready}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 deselect after reset", 64'(req_ready), 64'd0);

        // Directed corners.
        run_op(2'b10, 2'b00, 7'h55, 16'h0, 5'd16, 16'hA5C3, 0);   // R6 full read
        run_op(2'b10, 2'b00, 7'h01, 16'h0, 5'd1,  16'h0001, 0);   // R6 one bit
        run_op(2'b10, 2'b00, 7'h7F, 16'h0, 5'd0,  16'h8001, 0);   // R3/R6 len 0 -> 16
        run_op(2'b01, 2'b00, 7'h2A, 16'hBEEF, 5'd0, 16'h0, 3);    // R3 write len 0
        run_op(2'b01, 2'b00, 7'h13, 16'h1234, 5'd20, 16'h0, 0);   // R3 len above 16
        run_op(2'b01, 2'b00, 7'h13, 16'h00F5, 5'd8, 16'h0, 1);    // R3 byte
        run_op(2'b00, 2'b11, 7'h7F, 16'hFFFF, 5'd16, 16'h0, 0);   // R2 R9 enable
        run_op(2'b00, 2'b00, 7'h7F, 16'hFFFF, 5'd16, 16'h0, 0);   // R2 R9 disable
        run_op(2'b00, 2'b10, 7'h00, 16'h0, 5'd16, 16'h0, 0);      // R2 R7 wipe-all
        run_op(2'b00, 2'b01, 7'h3C, 16'hC0DE, 5'd16, 16'h0, 9);   // R7 last sample ready
        run_op(2'b11, 2'b00, 7'h40, 16'h0, 5'd16, 16'h0, 10);     // R8 timeout
        run_op(2'b11, 2'b00, 7'h41, 16'h0, 5'd16, 16'h0, 11);     // R8 timeout

        for (int n = 0; n < 30; n++) begin
            run_op(2'($urandom_range(3)), 2'($urandom_range(3)), ADDR_W'($urandom),
                   16'($urandom), 5'($urandom_range(31)), 16'($urandom),
                   int'($urandom_range(11)));
        end

        chk(min_hi >= DIV, "R4 clock high time", 64'(min_hi), 64'(DIV));
        chk(min_lo >= DIV, "R4 clock low and select lead", 64'(min_lo), 64'(DIV));
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule